// File: doc/BRIEF.md
# Seven-Level Staircase Gate Pattern Generator

This block produces the switch gate signals for one phase of an asymmetric cascaded inverter made of two H-bridges. The bridges are fed from DC sources weighted 1 unit and 2 units, so between them they can place any whole level from -3 to +3 units across the load. There is no carrier and no comparator. A four-bit step counter, advanced by a step tick, is decoded straight into a symmetric staircase. The staircase climbs and then descends during the positive half cycle, and does the same mirrored below zero during the negative half cycle.

The step tick is expected once every 1.25 ms, which gives 16 steps per 20 ms period (50 Hz). The top counter bit selects polarity. The next bit decides whether the low two bits are used as they are (rising) or inverted (falling). The resulting two-bit magnitude maps bit for bit onto the 1-unit and 2-unit bridges. Every output is registered, so gates move only on a clock edge where the tick is high. A signed level code comes out alongside the gates for checking.

Top module: `stair_gate_gen`

## Requirements
- R1: Synchronous active-high reset clears the step counter, drives `level_o` to 0 and puts both bridges in the zero state (`gate_o` = 8'hAA). Reset takes priority over `step_i`.
- R2: Each clock edge with `step_i` high advances the step by one, wrapping after 16 steps. From reset, the level after k steps is entry (k mod 16) of the sequence 0,1,2,3,3,2,1,0,0,-1,-2,-3,-3,-2,-1,0.
- R3: On a clock edge with `step_i` low, `gate_o` and `level_o` hold their values.
- R4: Steps 8 to 15 of the cycle give levels of zero or below, and steps 0 to 7 give levels of zero or above.
- R5: In the second quarter of each half cycle (step bit 2 set), the magnitude is the bitwise inverse of the low two step bits, so the staircase descends.
- R6: Bridge 0 (1 unit) contributes exactly when magnitude bit 0 is set, and bridge 1 (2 units) contributes exactly when magnitude bit 1 is set.
- R7: A bridge contributing a positive level turns on its switches 1 and 4 only. A bridge contributing a negative level turns on its switches 2 and 3 only. Switch k (1..4) of bridge b sits at `gate_o` bit 4*b+k-1.
- R8: A bridge that does not contribute is in the zero state: switches 2 and 4 on, switches 1 and 3 off (nibble 4'b1010).
- R9: Switches 1 and 2 of a bridge (one leg) are never on together, and neither are switches 3 and 4 (the other leg).
- R10: `level_o` is a two's-complement 3-bit code that always stays within -3..+3, so 3'b100 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step tick that advances the staircase by one step |
| gate_o | output | 8 | Switch gates, four per bridge, bridge 0 in bits 3:0 |
| level_o | output | 3 | Signed level currently applied, in units |

## Verification
Two unbroken runs of 32 ticks walk through every step twice. This separates the rising and falling quarters and both polarities, and it covers the wrap from step 15 back to 0. A sparse pattern, with a tick on only every third cycle, shows whether the outputs hold between ticks or move on edges without a tick. A reset issued in the middle of a cycle while the tick is high confirms that reset wins over the step and that the sequence restarts at level 0. On every result the gate nibbles are compared against the expected level, bridge by bridge, which catches swapped bridge weights, swapped switch pairs and a wrong zero state.

// File: rtl/stair_pkg.sv
package stair_pkg;

    localparam int STEP_W     = 2;
    localparam int CNT_W      = STEP_W + 2;
    localparam int NUM_BR     = STEP_W;
    localparam int LVL_W      = STEP_W + 1;
    localparam int SW_PER_BR  = 4;
    localparam int GATE_W     = NUM_BR * SW_PER_BR;

    typedef logic [STEP_W-1:0]       mag_t;
    typedef logic [CNT_W-1:0]        cnt_t;
    typedef logic signed [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic neg;
        mag_t mag;
    } step_t;

    typedef enum logic [1:0] {
        BR_ZERO = 2'd0,
        BR_POS  = 2'd1,
        BR_NEG  = 2'd2
    } br_mode_e;

    // switch 1 is the least significant bit
    typedef struct packed {
        logic s4;
        logic s3;
        logic s2;
        logic s1;
    } br_gate_t;

    localparam br_gate_t ZERO_GATES = '{s4: 1'b1, s3: 1'b0, s2: 1'b1, s1: 1'b0};

    function automatic br_gate_t gates_of(br_mode_e m);
        br_gate_t g;
        case (m)
            BR_POS:  g = '{s4: 1'b1, s3: 1'b0, s2: 1'b0, s1: 1'b1};
            BR_NEG:  g = '{s4: 1'b0, s3: 1'b1, s2: 1'b1, s1: 1'b0};
            default: g = ZERO_GATES;
        endcase
        return g;
    endfunction

    function automatic step_t phase_decode(cnt_t c);
        step_t s;
        s.neg = c[CNT_W-1];
        s.mag = c[CNT_W-2] ? ~c[STEP_W-1:0] : c[STEP_W-1:0];
        return s;
    endfunction

    function automatic lvl_t level_of(step_t s);
        lvl_t m;
        m = lvl_t'({1'b0, s.mag});
        return s.neg ? -m : m;
    endfunction

endpackage

// File: rtl/stair_counter.sv
module stair_counter
    import stair_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output cnt_t cnt_q,
    output cnt_t cnt_nxt
);

    always_comb begin
        cnt_nxt = step_i ? cnt_q + 1'b1 : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // R2: one step per tick, wrapping naturally
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (step_i && !rst) |=> (cnt_q == cnt_t'($past(cnt_q) + 1'b1)));

    // R3: counter frozen without tick
    a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !rst) |=> $stable(cnt_q));

endmodule

// File: rtl/stair_phase.sv
module stair_phase
    import stair_pkg::*;
(
    input  cnt_t  cnt_i,
    output step_t step_o,
    output lvl_t  level_o
);

    always_comb begin
        step_o  = phase_decode(cnt_i);
        level_o = level_of(step_o);
    end

endmodule

// File: rtl/bridge_cell.sv
module bridge_cell
    import stair_pkg::*;
(
    input  logic     active_i,
    input  logic     neg_i,
    output br_gate_t gate_o
);

    br_mode_e mode;

    always_comb begin
        if (!active_i) begin
            mode = BR_ZERO;
        end else if (neg_i) begin
            mode = BR_NEG;
        end else begin
            mode = BR_POS;
        end
        gate_o = gates_of(mode);
    end

endmodule

// File: rtl/stair_gate_gen.sv
module stair_gate_gen
    import stair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [GATE_W-1:0] gate_o,
    output logic [LVL_W-1:0]  level_o
);

    cnt_t     cnt_q;
    cnt_t     cnt_nxt;
    step_t    step_nxt;
    lvl_t     lvl_nxt;
    br_gate_t br_nxt [NUM_BR];
    br_gate_t br_q   [NUM_BR];
    lvl_t     lvl_q;

    stair_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_i),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    // decode the upcoming count so gates land on the same edge as the count
    stair_phase u_phase (
        .cnt_i   (cnt_nxt),
        .step_o  (step_nxt),
        .level_o (lvl_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (step_i) begin
            lvl_q <= lvl_nxt;
        end
    end

    assign level_o = lvl_q;

    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
        bridge_cell u_cell (
            .active_i (step_nxt.mag[b]),
            .neg_i    (step_nxt.neg),
            .gate_o   (br_nxt[b])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                br_q[b] <= ZERO_GATES;
            end else if (step_i) begin
                br_q[b] <= br_nxt[b];
            end
        end

        assign gate_o[b*SW_PER_BR +: SW_PER_BR] = br_q[b];

        // R9: no shoot-through in either leg of this bridge
        a_r9_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(br_q[b].s1 && br_q[b].s2) && !(br_q[b].s3 && br_q[b].s4));

        // R4: a negative level never leaves a bridge in the positive pair
        a_r4_polarity: assert property (@(posedge clk) disable iff (rst)
            (lvl_q < 0) |-> !(br_q[b].s1 && br_q[b].s4));

        // R8: zero level means every bridge is in its zero state
        a_r8_zero_state: assert property (@(posedge clk) disable iff (rst)
            (lvl_q == 0) |-> (br_q[b] == ZERO_GATES));
    end

    // R10: the unused most-negative code never appears
    a_r10_range: assert property (@(posedge clk) disable iff (rst)
        lvl_q != lvl_t'({1'b1, {(LVL_W-1){1'b0}}}));

    // R3: outputs frozen without tick
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !rst) |=> ($stable(gate_o) && $stable(level_o)));

endmodule

// File: tb/test_stair_gate_gen.sv
module test_stair_gate_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_i = 1'b0;
    logic [7:0] gate_o;
    logic [2:0] level_o;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    int cycles = 0;
    bit done   = 0;

    typedef struct {
        int    lvl;
        string tag;
    } item_t;

    item_t q[$];

    const int seq[16] = '{0, 1, 2, 3, 3, 2, 1, 0, 0, -1, -2, -3, -3, -2, -1, 0};

    always #2.5 clk = ~clk;

    stair_gate_gen i_stair_gate_gen (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_i),
        .gate_o  (gate_o),
        .level_o (level_o)
    );

    function automatic logic [3:0] exp_nib(int lvl, int b);
        int m;
        m = (lvl < 0) ? -lvl : lvl;
        if (((m >> b) & 1) == 0) return 4'b1010;
        return (lvl < 0) ? 4'b0110 : 4'b1001;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        item_t it;
        @(negedge clk);
        rst    = 1'b1;
        step_i = 1'b1;
        model  = 0;
        it.lvl = 0;
        it.tag = "R1";
        q.push_back(it);
    endtask

    task automatic drive(bit v);
        item_t it;
        @(negedge clk);
        rst    = 1'b0;
        step_i = v;
        if (v) model = (model + 1) % 16;
        it.lvl = seq[model];
        if (!v)              it.tag = "R3";
        else if (model >= 8) it.tag = "R4";
        else if (model >= 4) it.tag = "R5";
        else                 it.tag = "R2";
        q.push_back(it);
    endtask

    // monitor: compare each expected item one step after its edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            int    act;
            it  = q.pop_front();
            act = $signed(level_o);
            check(act == it.lvl, it.tag, act, it.lvl);
            check(act >= -3 && act <= 3, "R10", act, it.lvl);
            for (int b = 0; b < 2; b++) begin
                logic [3:0] nib;
                logic [3:0] en;
                int         m;
                nib = gate_o[b*4 +: 4];
                en  = exp_nib(it.lvl, b);
                m   = (it.lvl < 0) ? -it.lvl : it.lvl;
                check(nib == en, (en == 4'b1010) ? "R8" : "R7", nib, en);
                check((nib != 4'b1010) == (((m >> b) & 1) == 1), "R6", nib, m);
                check(!(nib[0] && nib[1]) && !(nib[2] && nib[3]), "R9", nib, en);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        do_reset();
        for (int i = 0; i < 32; i++) drive(1'b1);
        for (int i = 0; i < 60; i++) drive(i % 3 == 0);
        for (int i = 0; i < 5; i++) drive(1'b1);
        do_reset();
        for (int i = 0; i < 32; i++) drive(1'b1);
        drive(1'b0);
        drive(1'b0);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule